// File: doc/BRIEF.md
# Dual-Bank Maskable Interrupt Controller

This block gathers level-sensitive interrupt requests from up to 64 on-chip peripherals, organised as a low bank (sources 0 to 31) and a high bank (sources 32 to 63). Each source has an enable bit and a route bit. An enabled source that is requesting drives either the normal interrupt line or the fast interrupt line, depending on its route bit. A third output tells the power controller that the chip should leave idle mode. A control bit decides whether disabled sources may also cause that wake.

Software reaches the block through a small register port. The port has a write strobe, a 4-bit word address, 32-bit write data and a 32-bit combinational read. Requests are never latched. A source counts as pending only while its peripheral holds the line high, and the raw lines can be read back directly. All three outputs are registered, so each one follows its inputs by exactly one clock.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: After reset, every enable bit, every route bit and the control bit are 0, and the normal, fast and wake outputs are 0.
- R2: A source whose request is high, whose enable bit is 1 and whose route bit is 0 drives `irq_o` high one clock later, and `fiq_o` stays low.
- R3: A source whose request is high, whose enable bit is 1 and whose route bit is 1 drives `fiq_o` high one clock later, and `irq_o` stays low.
- R4: A source whose enable bit is 0 drives neither `irq_o` nor `fiq_o`, whatever its route bit.
- R5: Source 32+k is governed by bit k of the high-bank registers (enable at address 5, route at address 7). The low-bank registers (enable at address 4, route at address 6) govern bit k of sources 0 to 31 only.
- R6: The raw request addresses (0 for low, 1 for high) return the request lines in the same cycle. A dropped request disappears from the read at once, and its output falls one clock later.
- R7: The masked status addresses (2 for low, 3 for high) return the request lines ANDed with the enable bits.
- R8: When bit 0 of the control register (address 8) is 1, `wake_o` is high one clock after any enabled source requests, and low when no enabled source requests.
- R9: When control bit 0 is 0, any requesting source drives `wake_o` high one clock later, even if it is disabled.
- R10: Writes to the read-only addresses (0 to 3) and to unmapped addresses (9 to 15) change no register. Reads of unmapped addresses return 0.
- R11: With control bit 0 set to 1, an enabled source routed to the fast line also wakes the chip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 64 | Level request lines; bit n is source n |
| wr_en | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |
| wake_o | output | 1 | Leave-idle request |

## Verification
The normal and fast lines can be asserted in the same cycle. The bench provokes this with a low-bank source routed to the normal line and a high-bank source routed to the fast line, both requesting together. It then checks that each line reflects only its own source, and that wake follows both. It also drops one request while the other is held, and checks that only the matching line falls. That confirms the two OR trees are independent and that neither request was latched.

// File: rtl/dbic_pkg.sv
package dbic_pkg;
    localparam int BANK_W_DEF    = 32;
    localparam int NUM_BANKS_DEF = 2;
    localparam int ADDR_W_DEF    = 4;

    // Address layout: the register kind selects a group of NUM_BANKS words
    typedef enum int {
        KIND_RAW   = 0,
        KIND_MSTAT = 1,
        KIND_EN    = 2,
        KIND_ROUTE = 3,
        KIND_CTRL  = 4
    } reg_kind_e;

    function automatic int reg_word(input int nb, input reg_kind_e kind, input int bank);
        return nb * int'(kind) + bank;
    endfunction
endpackage

// File: rtl/dbic_bank.sv
module dbic_bank
    import dbic_pkg::*;
#(
    parameter int W   = BANK_W_DEF,
    parameter int NB  = NUM_BANKS_DEF,
    parameter int IDX = 0,
    parameter int AW  = ADDR_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [W-1:0]  req_i,
    output logic [W-1:0]  en_o,
    output logic [W-1:0]  route_o,
    output logic          norm_o,
    output logic          fast_o,
    output logic          live_o,
    output logic          any_o
);
    localparam logic [AW-1:0] EN_ADR    = AW'(reg_word(NB, KIND_EN, IDX));
    localparam logic [AW-1:0] ROUTE_ADR = AW'(reg_word(NB, KIND_ROUTE, IDX));

    typedef struct packed {
        logic [W-1:0] en;
        logic [W-1:0] route;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (wr_addr == EN_ADR))    st_d.en    = wr_data;
        if (wr_en && (wr_addr == ROUTE_ADR)) st_d.route = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o    = st_q.en;
    assign route_o = st_q.route;
    assign norm_o  = |(req_i & st_q.en & ~st_q.route);
    assign fast_o  = |(req_i & st_q.en & st_q.route);
    assign live_o  = |(req_i & st_q.en);
    assign any_o   = |req_i;
endmodule

// File: rtl/dbic_rdmux.sv
module dbic_rdmux
    import dbic_pkg::*;
#(
    parameter int W  = BANK_W_DEF,
    parameter int NB = NUM_BANKS_DEF,
    parameter int AW = ADDR_W_DEF
) (
    input  logic [AW-1:0]   addr_i,
    input  logic [NB*W-1:0] raw_i,
    input  logic [NB*W-1:0] en_i,
    input  logic [NB*W-1:0] route_i,
    input  logic            ctrl_i,
    output logic [W-1:0]    rd_data
);
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NB; b++) begin
            if (int'(addr_i) == reg_word(NB, KIND_RAW, b))   rd_data = raw_i[b*W +: W];
            if (int'(addr_i) == reg_word(NB, KIND_MSTAT, b)) rd_data = raw_i[b*W +: W] & en_i[b*W +: W];
            if (int'(addr_i) == reg_word(NB, KIND_EN, b))    rd_data = en_i[b*W +: W];
            if (int'(addr_i) == reg_word(NB, KIND_ROUTE, b)) rd_data = route_i[b*W +: W];
        end
        if (int'(addr_i) == reg_word(NB, KIND_CTRL, 0)) rd_data = W'(ctrl_i);
    end
endmodule

// File: rtl/dual_bank_irq_ctrl.sv
module dual_bank_irq_ctrl
    import dbic_pkg::*;
#(
    parameter int BANK_W    = BANK_W_DEF,
    parameter int NUM_BANKS = NUM_BANKS_DEF,
    parameter int ADDR_W    = ADDR_W_DEF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [BANK_W*NUM_BANKS-1:0]   src_i,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [BANK_W-1:0]             wr_data,
    output logic [BANK_W-1:0]             rd_data,
    output logic                          irq_o,
    output logic                          fiq_o,
    output logic                          wake_o
);
    localparam int NUM_SRC = BANK_W * NUM_BANKS;
    localparam logic [ADDR_W-1:0] CTRL_ADR = ADDR_W'(reg_word(NUM_BANKS, KIND_CTRL, 0));

    typedef struct packed {
        logic wake_sel;
        logic irq;
        logic fiq;
        logic wake;
    } top_st_t;

    top_st_t top_d, top_q;

    logic [NUM_SRC-1:0]   en_all;
    logic [NUM_SRC-1:0]   route_all;
    logic [NUM_BANKS-1:0] norm_v;
    logic [NUM_BANKS-1:0] fast_v;
    logic [NUM_BANKS-1:0] live_v;
    logic [NUM_BANKS-1:0] any_v;
    logic                 wake_sel;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dbic_bank #(
            .W   (BANK_W),
            .NB  (NUM_BANKS),
            .IDX (b),
            .AW  (ADDR_W)
        ) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_addr (addr_i),
            .wr_data (wr_data),
            .req_i   (src_i[b*BANK_W +: BANK_W]),
            .en_o    (en_all[b*BANK_W +: BANK_W]),
            .route_o (route_all[b*BANK_W +: BANK_W]),
            .norm_o  (norm_v[b]),
            .fast_o  (fast_v[b]),
            .live_o  (live_v[b]),
            .any_o   (any_v[b])
        );
    end

    always_comb begin
        top_d = top_q;
        if (wr_en && (addr_i == CTRL_ADR)) top_d.wake_sel = wr_data[0];
        top_d.irq  = |norm_v;
        top_d.fiq  = |fast_v;
        top_d.wake = top_q.wake_sel ? (|live_v) : (|any_v);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign wake_sel = top_q.wake_sel;
    assign irq_o    = top_q.irq;
    assign fiq_o    = top_q.fiq;
    assign wake_o   = top_q.wake;

    dbic_rdmux #(
        .W  (BANK_W),
        .NB (NUM_BANKS),
        .AW (ADDR_W)
    ) rdmux_i (
        .addr_i  (addr_i),
        .raw_i   (src_i),
        .en_i    (en_all),
        .route_i (route_all),
        .ctrl_i  (wake_sel),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/dbic_chk.sv
module dbic_chk #(
    parameter int N = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] src_i,
    input logic [N-1:0] en_all,
    input logic [N-1:0] route_all,
    input logic         wake_sel,
    input logic         irq_o,
    input logic         fiq_o,
    input logic         wake_o
);
    p_irq_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_i & en_all & ~route_all)) |=> irq_o);

    p_irq_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(src_i & en_all & ~route_all)) |=> !irq_o);

    p_fiq_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_i & en_all & route_all)) |=> fiq_o);

    p_fiq_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(src_i & en_all & route_all)) |=> !fiq_o);

    p_masked_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_i & en_all) == '0) |=> (!irq_o && !fiq_o));

    p_wake_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_sel && ((src_i & en_all) == '0)) |=> !wake_o);

    p_wake_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_sel && (|src_i)) |=> wake_o);

    p_wake_fast_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_sel && (|(src_i & en_all & route_all))) |=> wake_o);
endmodule

bind dual_bank_irq_ctrl dbic_chk #(
    .N (BANK_W * NUM_BANKS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .en_all    (en_all),
    .route_all (route_all),
    .wake_sel  (wake_sel),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .wake_o    (wake_o)
);

// File: tb/dual_bank_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module dual_bank_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq, wake;

    int checks = 0;
    int errors = 0;

    localparam logic [3:0] A_RAW_LO = 4'd0, A_RAW_HI = 4'd1, A_MST_LO = 4'd2, A_MST_HI = 4'd3,
                           A_EN_LO = 4'd4, A_EN_HI = 4'd5, A_RT_LO = 4'd6, A_RT_HI = 4'd7,
                           A_CTRL = 4'd8;

    always #4 clk = ~clk;

    dual_bank_irq_ctrl dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src),
        .wr_en   (wr_en),
        .addr_i  (addr),
        .wr_data (wdata),
        .rd_data (rdata),
        .irq_o   (irq),
        .fiq_o   (fiq),
        .wake_o  (wake)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_lines(input string req, input logic ei, input logic ef, input logic ew);
        chk(req, "irq_o", 32'(irq), 32'(ei));
        chk(req, "fiq_o", 32'(fiq), 32'(ef));
        chk(req, "wake_o", 32'(wake), 32'(ew));
    endtask

    task automatic clear_all();
        src = '0;
        wr(A_EN_LO, 0); wr(A_EN_HI, 0); wr(A_RT_LO, 0); wr(A_RT_HI, 0); wr(A_CTRL, 0);
        settle();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk_lines("R1", 0, 0, 0);
        rd(A_EN_LO, v); chk("R1", "enable low", v, 0);
        rd(A_EN_HI, v); chk("R1", "enable high", v, 0);
        rd(A_RT_LO, v); chk("R1", "route low", v, 0);
        rd(A_RT_HI, v); chk("R1", "route high", v, 0);
        rd(A_CTRL, v);  chk("R1", "control", v, 0);
    endtask

    task automatic t_normal_fast();
        src[5] = 1'b1;
        wr(A_EN_LO, 32'h20);
        settle();
        chk_lines("R2", 1, 0, 1);
        wr(A_RT_LO, 32'h20);
        settle();
        chk_lines("R3", 0, 1, 1);
        wr(A_EN_LO, 32'h0);
        settle();
        chk("R4", "irq_o masked", 32'(irq), 0);
        chk("R4", "fiq_o masked", 32'(fiq), 0);
        clear_all();
    endtask

    task automatic t_high_bank();
        logic [31:0] v;
        src[40] = 1'b1;
        wr(A_EN_LO, 32'h100);
        settle();
        chk("R5", "irq_o with low bit 8 only", 32'(irq), 0);
        wr(A_EN_HI, 32'h100);
        settle();
        chk("R5", "irq_o with high bit 8", 32'(irq), 1);
        rd(A_RAW_HI, v); chk("R6", "raw high", v, 32'h100);
        src[40] = 1'b0;
        #1 v = rdata;
        chk("R6", "raw high after drop", v, 0);
        chk("R6", "irq_o before edge", 32'(irq), 1);
        settle();
        chk("R6", "irq_o after drop", 32'(irq), 0);
        clear_all();
    endtask

    task automatic t_mstat();
        logic [31:0] v;
        src[3] = 1'b1; src[7] = 1'b1; src[33] = 1'b1;
        wr(A_EN_LO, 32'h80);
        rd(A_RAW_LO, v); chk("R7", "raw low", v, 32'h88);
        rd(A_MST_LO, v); chk("R7", "masked low", v, 32'h80);
        rd(A_MST_HI, v); chk("R7", "masked high", v, 32'h0);
        clear_all();
    endtask

    task automatic t_wake();
        src[12] = 1'b1;
        settle();
        chk_lines("R9", 0, 0, 1);
        wr(A_CTRL, 32'h1);
        settle();
        chk_lines("R8", 0, 0, 0);
        wr(A_RT_LO, 32'h1000);
        wr(A_EN_LO, 32'h1000);
        settle();
        chk_lines("R11", 0, 1, 1);
        wr(A_RT_LO, 32'h0);
        settle();
        chk_lines("R8", 1, 0, 1);
        clear_all();
    endtask

    task automatic t_both_lines();
        src[0] = 1'b1; src[33] = 1'b1;
        wr(A_EN_LO, 32'h1);
        wr(A_EN_HI, 32'h2);
        wr(A_RT_HI, 32'h2);
        wr(A_CTRL, 32'h1);
        settle();
        chk_lines("R2", 1, 1, 1);
        src[0] = 1'b0;
        settle();
        chk_lines("R3", 0, 1, 1);
        clear_all();
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        wr(A_EN_LO, 32'h5);
        wr(A_RAW_LO, 32'hFFFF_FFFF);
        wr(A_MST_HI, 32'hFFFF_FFFF);
        wr(4'd9, 32'hFFFF_FFFF);
        wr(4'd15, 32'hFFFF_FFFF);
        rd(A_EN_LO, v); chk("R10", "enable low", v, 32'h5);
        rd(A_EN_HI, v); chk("R10", "enable high", v, 0);
        rd(A_RT_LO, v); chk("R10", "route low", v, 0);
        rd(A_RT_HI, v); chk("R10", "route high", v, 0);
        rd(A_CTRL, v);  chk("R10", "control", v, 0);
        rd(4'd15, v);   chk("R10", "unmapped read", v, 0);
        settle();
        chk_lines("R10", 0, 0, 0);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal_fast();
        t_high_bank();
        t_mstat();
        t_wake();
        t_both_lines();
        t_ignored();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual still running, expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule